// File: doc/BRIEF.md
# Signed Integer to Double Converter

This block turns a signed integer operand into an IEEE 754 double-precision value and writes that value into the low 64-bit lane of a 256-bit vector destination. Two control inputs together pick the source width. The whole 64-bit operand is used only when both of them are set. Otherwise the low 32 bits are taken as a signed value. A 2-bit rounding field picks how a 64-bit magnitude that does not fit in 53 significant bits is rounded. A precision flag is raised whenever the result differs from the exact integer.

The lanes above the result are merged in one of two ways. In the legacy form, the caller's current destination contents pass through unchanged. In the VEX form, bits 127:64 come from a 128-bit first vector source and bits 255:128 are cleared. The block accepts one conversion per clock and registers the result. A two-state occupancy machine drives the output valid: ST_EMPTY means no result is presented and ST_FULL means a result is presented. Transition T_LOAD goes to ST_FULL on any cycle with `in_valid` high. Transition T_DRAIN goes to ST_EMPTY on any cycle with `in_valid` low. From either state, the next state depends only on `in_valid`.

Top module: `sint_to_f64_merge`

## Requirements
- R1: The 64-bit `in_int` is converted only when `in_mode64` and `in_size64` are both 1. In every other case, `in_int[31:0]` is converted as a signed 32-bit value and bits 63:32 are ignored.
- R2: `out_dst[63:0]` holds the IEEE 754 double encoding: sign in bit 63, exponent biased by 1023 in bits 62:52, fraction in bits 51:0. Zero gives +0.0 (all bits 0). The most negative 64-bit integer gives exactly 0xC3E0000000000000.
- R3: With `in_vex`=0 (legacy form), `out_dst[255:64]` equals `in_dst[255:64]` of the accepted cycle.
- R4: With `in_vex`=1, `out_dst[127:64]` equals `in_src1[127:64]` of the accepted cycle.
- R5: With `in_vex`=1, `out_dst[255:128]` is zero.
- R6: `in_rc` picks the rounding of an inexact result: 00 = nearest with ties to even, 01 = toward negative infinity, 10 = toward positive infinity, 11 = toward zero.
- R7: `out_inexact` is 1 exactly when the rounded result differs from the integer. On the 32-bit path it is always 0.
- R8: If rounding carries out of the fraction, the exponent goes up by one and the fraction becomes zero. For example, 0x7FFFFFFFFFFFFFFF rounded to nearest gives 0x43E0000000000000, and rounded toward zero gives 0x43DFFFFFFFFFFFFF.
- R9: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low after each cycle with `in_valid` low. Reset clears `out_valid`, `out_dst` and `out_inexact`.
- R10: A cycle with `in_valid` low leaves `out_dst` and `out_inexact` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A conversion is presented this cycle |
| in_int | input | 64 | Signed integer source |
| in_src1 | input | 128 | First vector source (VEX form) |
| in_dst | input | 256 | Current destination contents (legacy form) |
| in_mode64 | input | 1 | 64-bit mode qualifier |
| in_size64 | input | 1 | 64-bit operand size qualifier |
| in_vex | input | 1 | 1 = VEX merge form, 0 = legacy merge form |
| in_rc | input | 2 | Rounding control (R6 encoding) |
| out_valid | output | 1 | Registered result is valid |
| out_dst | output | 256 | New destination contents |
| out_inexact | output | 1 | Precision flag |

## Verification
The bench sweeps every leading-one position, with offsets of one step and of half a step around each power of two, in both signs and under all four rounding modes. A leading-one detector that is off by one, or a guard/sticky split at the wrong bit, therefore shows up as a wrong exponent or a wrong last fraction bit. The boundary cases are checked against literal encodings: the most negative 64-bit value, where a sign-magnitude step that overflows would give a garbage magnitude, and the largest positive value, where a missing carry into the exponent would give 2^62 instead of 2^63. The 32-bit path is driven with garbage in the upper source bits and with only one of the two width qualifiers set, so a design that gates on only one qualifier converts the wrong operand. Each merge form is driven with patterned lane data, so a swapped or uncleared upper lane is caught directly.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_ZERO = 2'b11
    } rc_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } occ_e;

    localparam int F64_W  = 64;
    localparam int FRAC_W = 52;
    localparam int EXP_W  = 11;
    localparam int BIAS   = 1023;
endpackage

// File: rtl/cvt_norm.sv
module cvt_norm #(
    parameter int SRC_W    = 64,
    parameter int NARROW_W = 32,
    localparam int POS_W   = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0] src,
    input  logic             wide,
    output logic             sign,
    output logic             zero,
    output logic [POS_W-1:0] lead,
    output logic [SRC_W-1:0] norm
);
    logic [SRC_W-1:0] sel;
    logic [SRC_W-1:0] mag;

    always_comb begin
        if (wide) sel = src;
        else      sel = {{(SRC_W-NARROW_W){src[NARROW_W-1]}}, src[NARROW_W-1:0]};
        sign = sel[SRC_W-1];
        mag  = sign ? (~sel + 1'b1) : sel;
        zero = (mag == '0);
    end

    always_comb begin
        lead = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (mag[i]) lead = POS_W'(i);
        end
    end

    assign norm = mag << (POS_W'(SRC_W-1) - lead);
endmodule

// File: rtl/cvt_round.sv
module cvt_round
    import cvt_pkg::*;
#(
    parameter int SRC_W  = 64,
    localparam int POS_W = $clog2(SRC_W),
    localparam int GRS_W = SRC_W - 1 - FRAC_W
) (
    input  logic             sign,
    input  logic             zero,
    input  logic [POS_W-1:0] lead,
    input  logic [SRC_W-1:0] norm,
    input  logic [1:0]       rc,
    output logic [F64_W-1:0] result,
    output logic             inexact
);
    logic [FRAC_W-1:0] frac;
    logic [GRS_W-1:0]  tail;
    logic              guard;
    logic              rest;
    logic              up;
    logic [FRAC_W:0]   sum;
    logic [EXP_W-1:0]  expo;

    always_comb begin
        frac    = norm[SRC_W-2 -: FRAC_W];
        tail    = norm[GRS_W-1:0];
        guard   = tail[GRS_W-1];
        rest    = |tail[GRS_W-2:0];
        inexact = |tail;
        unique case (rc_e'(rc))
            RC_NEAR: up = guard & (rest | frac[0]);
            RC_DOWN: up = inexact & sign;
            RC_UP:   up = inexact & ~sign;
            RC_ZERO: up = 1'b0;
        endcase
        sum  = {1'b0, frac} + (FRAC_W+1)'(up);
        expo = EXP_W'(BIAS) + EXP_W'(lead) + EXP_W'(sum[FRAC_W]);
        if (zero) result = '0;
        else      result = {sign, expo, sum[FRAC_W-1:0]};
    end
endmodule

// File: rtl/cvt_merge.sv
module cvt_merge #(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 64,
    parameter int SRC1_W = 128,
    localparam int LANES = VEC_W / LANE_W,
    localparam int S1_LN = SRC1_W / LANE_W
) (
    input  logic [LANE_W-1:0] lane0,
    input  logic [VEC_W-1:0]  dst_old,
    input  logic [SRC1_W-1:0] src1,
    input  logic              vex,
    output logic [VEC_W-1:0]  merged
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_res
            assign merged[LANE_W-1:0] = lane0;
        end else if (k < S1_LN) begin : g_src1
            assign merged[k*LANE_W +: LANE_W] =
                vex ? src1[k*LANE_W +: LANE_W] : dst_old[k*LANE_W +: LANE_W];
        end else begin : g_upper
            assign merged[k*LANE_W +: LANE_W] =
                vex ? '0 : dst_old[k*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/sint_to_f64_merge.sv
module sint_to_f64_merge
    import cvt_pkg::*;
#(
    parameter int SRC_W    = 64,
    parameter int NARROW_W = 32,
    parameter int VEC_W    = 256,
    parameter int SRC1_W   = 128,
    localparam int POS_W   = $clog2(SRC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SRC_W-1:0]  in_int,
    input  logic [SRC1_W-1:0] in_src1,
    input  logic [VEC_W-1:0]  in_dst,
    input  logic              in_mode64,
    input  logic              in_size64,
    input  logic              in_vex,
    input  logic [1:0]        in_rc,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_dst,
    output logic              out_inexact
);
    occ_e             state, state_nx;
    logic             n_sign, n_zero;
    logic [POS_W-1:0] n_lead;
    logic [SRC_W-1:0] n_norm;
    logic [F64_W-1:0] r_val;
    logic             r_inx;
    logic [VEC_W-1:0] m_dst;

    cvt_norm #(.SRC_W(SRC_W), .NARROW_W(NARROW_W)) u_norm (
        .src(in_int), .wide(in_mode64 & in_size64),
        .sign(n_sign), .zero(n_zero), .lead(n_lead), .norm(n_norm)
    );

    cvt_round #(.SRC_W(SRC_W)) u_round (
        .sign(n_sign), .zero(n_zero), .lead(n_lead), .norm(n_norm),
        .rc(in_rc), .result(r_val), .inexact(r_inx)
    );

    cvt_merge #(.VEC_W(VEC_W), .LANE_W(F64_W), .SRC1_W(SRC1_W)) u_merge (
        .lane0(r_val), .dst_old(in_dst), .src1(in_src1),
        .vex(in_vex), .merged(m_dst)
    );

    always_comb begin
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_dst     <= '0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_dst     <= m_dst;
            out_inexact <= r_inx;
        end
    end

    assign out_valid = (state == ST_FULL);
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [63:0]  in_int,
    input logic [127:0] in_src1,
    input logic [255:0] in_dst,
    input logic         in_mode64,
    input logic         in_size64,
    input logic         in_vex,
    input logic         out_valid,
    input logic [255:0] out_dst,
    input logic         out_inexact
);
    logic wide_q;
    logic src_zero;
    logic src_sign;
    assign wide_q   = in_mode64 && in_size64;
    assign src_zero = wide_q ? (in_int == 64'd0) : (in_int[31:0] == 32'd0);
    assign src_sign = wide_q ? in_int[63] : in_int[31];

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_dst) && $stable(out_inexact)));
    assert_narrow_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_q) |=> !out_inexact);
    assert_zero_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_zero) |=> (out_dst[63:0] == 64'd0 && !out_inexact));
    assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dst[63] == $past(src_sign)));
    assert_legacy_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_vex) |=> (out_dst[255:64] == $past(in_dst[255:64])));
    assert_vex_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vex) |=> (out_dst[127:64] == $past(in_src1[127:64])));
    assert_vex_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vex) |=> (out_dst[255:128] == 128'd0));
endmodule

bind sint_to_f64_merge cvt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
    .in_src1(in_src1), .in_dst(in_dst), .in_mode64(in_mode64),
    .in_size64(in_size64), .in_vex(in_vex), .out_valid(out_valid),
    .out_dst(out_dst), .out_inexact(out_inexact)
);

// File: tb/sim_sint_to_f64_merge.sv
module sim_sint_to_f64_merge;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  in_int = '0;
    logic [127:0] in_src1 = '0;
    logic [255:0] in_dst = '0;
    logic         in_mode64 = 1'b0;
    logic         in_size64 = 1'b0;
    logic         in_vex = 1'b0;
    logic [1:0]   in_rc = 2'b00;
    logic         out_valid;
    logic [255:0] out_dst;
    logic         out_inexact;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    logic [63:0] lfsr = 64'h9E3779B97F4A7C15;

    sint_to_f64_merge u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
        .in_src1(in_src1), .in_dst(in_dst), .in_mode64(in_mode64),
        .in_size64(in_size64), .in_vex(in_vex), .in_rc(in_rc),
        .out_valid(out_valid), .out_dst(out_dst), .out_inexact(out_inexact)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] step(input logic [63:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction

    // arithmetic reference: exponent by repeated halving, rounding by remainder comparison
    function automatic logic [63:0] ref_cvt(input logic [63:0] v, input logic wide,
                                            input logic [1:0] rc, output logic inx);
        logic signed [63:0] s;
        logic [63:0] m, t, q, r, half;
        logic neg, up;
        int e, sh;
        s   = wide ? v : {{32{v[31]}}, v[31:0]};
        neg = (s < 0);
        m   = neg ? (64'd0 - s) : s;
        inx = 1'b0;
        if (m == 64'd0) return 64'd0;
        e = 0; t = m;
        while (t > 64'd1) begin t = t >> 1; e++; end
        if (e <= 52) begin
            q = m << (52 - e);
            up = 1'b0;
        end else begin
            sh   = e - 52;
            q    = m >> sh;
            r    = m - (q << sh);
            half = 64'd1 << (sh - 1);
            inx  = (r != 64'd0);
            case (rc)
                2'b00:   up = (r > half) || (r == half && q[0]);
                2'b01:   up = inx && neg;
                2'b10:   up = inx && !neg;
                default: up = 1'b0;
            endcase
            q = q + {63'd0, up};
            if (q == (64'd1 << 53)) begin q = q >> 1; e++; end
        end
        return {neg, 11'(e + 1023), q[51:0]};
    endfunction

    // drive at a falling edge, compare at the next falling edge (one register stage)
    task automatic run_op(input logic [63:0] v, input logic m64, input logic s64,
                          input logic vex, input logic [1:0] rc,
                          input logic [127:0] s1, input logic [255:0] d, input string tag);
        logic inx;
        logic [63:0]  lo;
        logic [255:0] full;
        lo   = ref_cvt(v, m64 && s64, rc, inx);
        full = vex ? {128'd0, s1[127:64], lo} : {d[255:64], lo};
        in_int = v; in_mode64 = m64; in_size64 = s64; in_vex = vex;
        in_rc = rc; in_src1 = s1; in_dst = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R9 valid"}, {255'd0, out_valid}, 256'd1);
        check({tag, " R2/R6 value"}, {192'd0, out_dst[63:0]}, {192'd0, lo});
        check({tag, " R7 inexact"}, {255'd0, out_inexact}, {255'd0, inx});
        if (vex) check({tag, " R4/R5 vex lanes"}, out_dst, full);
        else     check({tag, " R3 legacy lanes"}, out_dst, full);
    endtask

    task automatic lit(input logic [63:0] v, input logic m64, input logic s64,
                       input logic [1:0] rc, input logic [63:0] exp, input logic exinx,
                       input string tag);
        in_int = v; in_mode64 = m64; in_size64 = s64; in_vex = 1'b0;
        in_rc = rc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {192'd0, out_dst[63:0]}, {192'd0, exp});
        check({tag, " flag"}, {255'd0, out_inexact}, {255'd0, exinx});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R9 reset valid", {255'd0, out_valid}, 256'd0);
        check("R9 reset dst", out_dst, 256'd0);
        check("R9 reset flag", {255'd0, out_inexact}, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // literal encodings
        lit(64'h8000000000000000, 1, 1, 2'b00, 64'hC3E0000000000000, 0, "R2 min int64");
        lit(64'd0,                1, 1, 2'b01, 64'h0000000000000000, 0, "R2 zero");
        lit(64'd1,                1, 1, 2'b00, 64'h3FF0000000000000, 0, "R2 one");
        lit(64'hFFFFFFFFFFFFFFFF, 1, 1, 2'b00, 64'hBFF0000000000000, 0, "R2 minus one");
        lit(64'h7FFFFFFFFFFFFFFF, 1, 1, 2'b00, 64'h43E0000000000000, 1, "R8 carry near");
        lit(64'h7FFFFFFFFFFFFFFF, 1, 1, 2'b11, 64'h43DFFFFFFFFFFFFF, 1, "R8 trunc zero");
        lit(64'h7FFFFFFFFFFFFFFF, 1, 1, 2'b01, 64'h43DFFFFFFFFFFFFF, 1, "R6 down pos");
        lit(64'h8000000000000001, 1, 1, 2'b01, 64'hC3E0000000000000, 1, "R6 down neg");
        lit(64'h8000000000000001, 1, 1, 2'b10, 64'hC3DFFFFFFFFFFFFF, 1, "R6 up neg");
        lit(64'h0020000000000001, 1, 1, 2'b00, 64'h4340000000000000, 1, "R6 tie even");
        lit(64'h0020000000000003, 1, 1, 2'b00, 64'h4340000000000002, 1, "R6 tie odd");
        lit(64'hDEADBEEF80000000, 1, 0, 2'b00, 64'hC1E0000000000000, 0, "R1 narrow size");
        lit(64'hDEADBEEF80000000, 0, 1, 2'b00, 64'hC1E0000000000000, 0, "R1 narrow mode");
        lit(64'h123456787FFFFFFF, 0, 0, 2'b10, 64'h41DFFFFFFFC00000, 0, "R1 narrow max");

        // sweep every leading-one position, sign, offset and rounding mode
        for (int rc = 0; rc < 4; rc++) begin
            for (int k = 0; k < 63; k++) begin
                for (int o = 0; o < 5; o++) begin
                    for (int sg = 0; sg < 2; sg++) begin
                        logic [63:0] b, v;
                        b = 64'd1 << k;
                        case (o)
                            0: v = b;
                            1: v = b - 64'd1;
                            2: v = b + 64'd1;
                            3: v = b + (b >> 11) + (b >> 12);
                            default: v = b | (b >> 53) | (b >> 60);
                        endcase
                        if (sg == 1) v = 64'd0 - v;
                        lfsr = step(lfsr);
                        run_op(v, 1, 1, lfsr[3], 2'(rc), {lfsr, ~lfsr},
                               {lfsr, lfsr ^ 64'h5A5A, ~lfsr, lfsr + 64'd7}, "R6 sweep64");
                    end
                end
            end
        end

        // narrow path sweep with garbage upper source bits and partial qualifiers
        for (int k = 0; k < 32; k++) begin
            for (int q = 0; q < 3; q++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    logic [31:0] n;
                    n = (32'd1 << k) - 32'(q);
                    if (sg == 1) n = 32'd0 - n;
                    lfsr = step(lfsr);
                    run_op({lfsr[63:32], n}, q == 1, q == 2, lfsr[5], lfsr[1:0],
                           {~lfsr, lfsr}, {4{lfsr}}, "R1 R7 sweep32");
                end
            end
        end

        // pseudo-random operands and merge data
        for (int i = 0; i < 1500; i++) begin
            lfsr = step(lfsr);
            run_op(lfsr >> lfsr[5:0], lfsr[7], lfsr[8] | lfsr[7], lfsr[9], lfsr[11:10],
                   {lfsr ^ 64'hF0F0, lfsr}, {lfsr, ~lfsr, lfsr + 64'd3, lfsr}, "R3 R4 R5 random");
        end

        // idle cycle with changed inputs: output must hold
        run_op(64'hFFFFFFFFFFFFFF01, 1, 1, 1'b0, 2'b00, {2{64'hAAAA}}, {4{64'h1234}}, "R10 pre");
        begin
            logic [255:0] held;
            logic hflag;
            held = out_dst; hflag = out_inexact;
            in_int = 64'h7FFFFFFFFFFFFFFF; in_vex = 1'b1; in_dst = '1; in_src1 = '1;
            in_valid = 1'b0;
            @(negedge clk);
            check("R10 hold dst", out_dst, held);
            check("R10 hold flag", {255'd0, out_inexact}, {255'd0, hflag});
            check("R9 idle valid", {255'd0, out_valid}, 256'd0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule